// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the processor-facing side of a plain 8-data-bit, no-parity, one-stop-bit serial controller. A host reaches eight byte-wide registers, each on a 32-bit-aligned byte offset. They hold four fixed identification bytes, a data port, a mixed control/status byte and a 16-bit baud divisor split over two bytes. Behind the registers sit three small engines. The first is a one-character transmit holding stage that a bit shifter drains. The second is a receive FIFO that a bit sampler fills. The third is a tick generator that paces both sides at four ticks per bit.

A write to the data port hands a character to the transmitter. A read from it takes the oldest received character. The control/status byte carries two interrupt enables, which the host sets and clears freely, and four FIFO and holding-stage flags, which writes cannot change. It also carries two sticky error flags, and the host clears these by writing a zero into their positions. One interrupt line serves both directions.

Top module: `serial_ctl_frontend`

## Requirements
- R1: Word offsets 0, 4, 8 and 12 return bytes 0 to 3 of the `ID_WORD` parameter, byte 0 being bits 7:0. Writes to them have no effect. Read data appears on `bus_rdata` one cycle after the read strobe and changes only on reads.
- R2: An offset whose two low bits are not zero is unmapped. A read of it returns 0, and a write to it changes nothing.
- R3: A write to offset 16 while the transmit stage is empty loads the character. `tx_pending` then rises, `tx_char` shows the character, and status bit 7 drops. A further write while the stage is occupied is ignored. A `tx_accept` pulse empties the stage.
- R4: A read of offset 16 returns the oldest received character and removes it, so characters come out in arrival order. A read while the FIFO is empty returns 0 and changes nothing.
- R5: The status byte sits at offset 20. Bit 3 is set when the FIFO holds `FIFO_DEPTH` characters. Bit 4 is set when it holds exactly one fewer. Bit 5 is set when it is empty. Bit 7 is set when the transmit stage is empty.
- R6: A receive push while the FIFO is full and not being read drops the character and sets status bit 1. A push with `rx_ferr` set stores the character and sets status bit 0.
- R7: A status write loads bit 2 (receive interrupt enable) and bit 6 (transmit interrupt enable) from the data. It clears bits 0 and 1 where a 0 is written and keeps them where a 1 is written. It leaves bits 3, 4, 5 and 7 unchanged.
- R8: `irq` is registered and follows the state one cycle later. It is high when bit 2 is set and the FIFO is not empty or an error bit is set. It is also high when bit 6 is set and bit 7 is set.
- R9: The divisor low byte sits at offset 24 and the high byte at offset 28, and both read back. `baud_tick` is one cycle wide with a period of divisor+1 cycles. A write to either byte restarts the count.
- R10: Reset leaves the status byte at 0xA0, the divisor at 0, `irq` low and `tx_pending` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined receive/transmit interrupt |
| tx_char | output | 8 | Character held for the transmitter |
| tx_pending | output | 1 | Transmit stage holds a character |
| tx_accept | input | 1 | Transmitter takes the held character |
| rx_char | input | 8 | Received character |
| rx_push | input | 1 | Store `rx_char` into the FIFO |
| rx_ferr | input | 1 | Stop bit missing on the pushed character |
| baud_tick | output | 1 | Quarter-bit tick pulse |

## Verification
The bench builds the block with `FIFO_DEPTH` = 4 and a distinct value in each byte of `ID_WORD`. With this depth, the one-room-left flag, the full flag and an overrun each arise after only a few pushes. A swapped identification byte would also show up. Divisors of 0, 3 and 258 cover the every-cycle tick, a short period and a period that needs the high byte.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  // word index decoded from byte offset bits [4:2]
  typedef enum logic [2:0] {
    RSEL_ID0  = 3'd0,
    RSEL_ID1  = 3'd1,
    RSEL_ID2  = 3'd2,
    RSEL_ID3  = 3'd3,
    RSEL_DATA = 3'd4,
    RSEL_STAT = 3'd5,
    RSEL_DIVL = 3'd6,
    RSEL_DIVH = 3'd7
  } reg_sel_e;

  // status byte bit positions
  localparam int unsigned SB_FERR  = 0;
  localparam int unsigned SB_OERR  = 1;
  localparam int unsigned SB_RXIE  = 2;
  localparam int unsigned SB_FULL  = 3;
  localparam int unsigned SB_ROOM1 = 4;
  localparam int unsigned SB_EMPTY = 5;
  localparam int unsigned SB_TXIE  = 6;
  localparam int unsigned SB_TXMT  = 7;

endpackage

// File: rtl/sfe_rx_fifo.sv
module sfe_rx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic [WIDTH-1:0]               din,
  input  logic                           pop,
  output logic [WIDTH-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           overrun
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH-1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop, do_push;

  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && ((cnt_q != CNT_MAX) || do_pop);
  assign overrun = push && !do_push;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = mem[rd_ptr_q];
  assign count = cnt_q;

  // R6: a push into a full FIFO that is not being read leaves it full
  a_r6_overrun_keeps_full: assert property (@(posedge clk) disable iff (rst)
    (push && (cnt_q == CNT_MAX) && !pop) |=> (cnt_q == CNT_MAX));

  // R4: a read while empty does not change the fill level
  a_r4_empty_pop_noop: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q == '0) && pop && !push) |=> (cnt_q == '0));

endmodule

// File: rtl/sfe_tx_hold.sv
module sfe_tx_hold #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             take,
  output logic             full,
  output logic [WIDTH-1:0] dout
);
  logic             full_q;
  logic [WIDTH-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (full_q) begin
      if (take) full_q <= 1'b0;
    end else if (load) begin
      full_q <= 1'b1;
      data_q <= din;
    end
  end

  assign full = full_q;
  assign dout = data_q;

  // R3: an occupied stage keeps its character until the transmitter takes it
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (full_q && !take) |=> (full_q && $stable(data_q)));

endmodule

// File: rtl/sfe_baud_gen.sv
module sfe_baud_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == div) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  // R9: with a nonzero divisor a tick is never followed by another tick
  a_r9_tick_single: assert property (@(posedge clk) disable iff (rst)
    (tick_q && (div != '0) && !reload) |=> !tick_q);

endmodule

// File: rtl/serial_ctl_frontend.sv
module serial_ctl_frontend
  import sfe_pkg::*;
#(
  parameter int unsigned   ADDR_W     = 5,
  parameter int unsigned   FIFO_DEPTH = 4,
  parameter logic [31:0]   ID_WORD    = 32'h0143_5253
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic [7:0]        tx_char,
  output logic              tx_pending,
  input  logic              tx_accept,
  input  logic [7:0]        rx_char,
  input  logic              rx_push,
  input  logic              rx_ferr,
  output logic              baud_tick
);
  localparam int unsigned DIV_W = 16;
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH+1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0] CNT_ROOM1 = CNT_W'(FIFO_DEPTH-1);

  // ---------------- address decode ----------------
  logic     upper_zero;
  logic     mapped;
  reg_sel_e rsel;

  generate
    if (ADDR_W > 5) begin : g_wide_addr
      assign upper_zero = (bus_addr[ADDR_W-1:5] == '0);
    end else begin : g_exact_addr
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign mapped = upper_zero && (bus_addr[1:0] == 2'b00);
  assign rsel   = reg_sel_e'(bus_addr[4:2]);

  logic acc_rd, acc_wr;
  logic data_rd, data_wr, stat_wr, divl_wr, divh_wr;

  assign acc_rd  = bus_en && !bus_we;
  assign acc_wr  = bus_en && bus_we;
  assign data_rd = acc_rd && mapped && (rsel == RSEL_DATA);
  assign data_wr = acc_wr && mapped && (rsel == RSEL_DATA);
  assign stat_wr = acc_wr && mapped && (rsel == RSEL_STAT);
  assign divl_wr = acc_wr && mapped && (rsel == RSEL_DIVL);
  assign divh_wr = acc_wr && mapped && (rsel == RSEL_DIVH);

  // ---------------- sub-blocks ----------------
  logic [7:0]       fifo_head;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_ovr;
  logic             tx_full;
  logic [DIV_W-1:0] div_q;

  sfe_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
    .clk     (clk),
    .rst     (rst),
    .push    (rx_push),
    .din     (rx_char),
    .pop     (data_rd),
    .dout    (fifo_head),
    .count   (fifo_cnt),
    .overrun (fifo_ovr)
  );

  sfe_tx_hold #(.WIDTH(8)) u_tx_hold (
    .clk  (clk),
    .rst  (rst),
    .load (data_wr),
    .din  (bus_wdata),
    .take (tx_accept),
    .full (tx_full),
    .dout (tx_char)
  );

  sfe_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst    (rst),
    .div    (div_q),
    .reload (divl_wr || divh_wr),
    .tick   (baud_tick)
  );

  assign tx_pending = tx_full;

  // ---------------- control and sticky errors ----------------
  logic rxie_q, txie_q, ferr_q, oerr_q;
  logic ferr_d, oerr_d;
  logic fifo_empty;

  assign fifo_empty = (fifo_cnt == '0);

  always_comb begin
    ferr_d = ferr_q;
    oerr_d = oerr_q;
    if (stat_wr) begin
      ferr_d = ferr_q & bus_wdata[SB_FERR];
      oerr_d = oerr_q & bus_wdata[SB_OERR];
    end
    if (rx_push && rx_ferr) ferr_d = 1'b1;
    if (fifo_ovr)           oerr_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxie_q <= 1'b0;
      txie_q <= 1'b0;
      ferr_q <= 1'b0;
      oerr_q <= 1'b0;
    end else begin
      ferr_q <= ferr_d;
      oerr_q <= oerr_d;
      if (stat_wr) begin
        rxie_q <= bus_wdata[SB_RXIE];
        txie_q <= bus_wdata[SB_TXIE];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else begin
      if (divl_wr) div_q[7:0]  <= bus_wdata;
      if (divh_wr) div_q[15:8] <= bus_wdata;
    end
  end

  logic [7:0] status_vec;
  always_comb begin
    status_vec           = '0;
    status_vec[SB_FERR]  = ferr_q;
    status_vec[SB_OERR]  = oerr_q;
    status_vec[SB_RXIE]  = rxie_q;
    status_vec[SB_FULL]  = (fifo_cnt == CNT_FULL);
    status_vec[SB_ROOM1] = (fifo_cnt == CNT_ROOM1);
    status_vec[SB_EMPTY] = fifo_empty;
    status_vec[SB_TXIE]  = txie_q;
    status_vec[SB_TXMT]  = !tx_full;
  end

  // ---------------- read mux ----------------
  logic [7:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (mapped) begin
      case (rsel)
        RSEL_ID0:  rd_val = ID_WORD[7:0];
        RSEL_ID1:  rd_val = ID_WORD[15:8];
        RSEL_ID2:  rd_val = ID_WORD[23:16];
        RSEL_ID3:  rd_val = ID_WORD[31:24];
        RSEL_DATA: rd_val = fifo_empty ? 8'h00 : fifo_head;
        RSEL_STAT: rd_val = status_vec;
        RSEL_DIVL: rd_val = div_q[7:0];
        RSEL_DIVH: rd_val = div_q[15:8];
        default:   rd_val = '0;
      endcase
    end
  end

  logic [7:0] rdata_q;
  logic       irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (acc_rd) rdata_q <= rd_val;
      irq_q <= (rxie_q && (!fifo_empty || ferr_q || oerr_q)) ||
               (txie_q && !tx_full);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  // ---------------- assertions ----------------
  // R2: unmapped reads return zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && !mapped) |=> (bus_rdata == 8'h00));

  // R1: read data holds when no read is made
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> $stable(bus_rdata));

  // R7: writing 0 to the frame error bit with no new error clears it
  a_r7_ferr_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !bus_wdata[SB_FERR] && !(rx_push && rx_ferr)) |=> !ferr_q);

  // R8: both enables off means the line is low one cycle later
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (!rxie_q && !txie_q) |=> !irq);

  // R4: reading an empty FIFO returns zero
  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (data_rd && fifo_empty) |=> (bus_rdata == 8'h00));

endmodule

// File: tb/test_serial_ctl_frontend.sv
module test_serial_ctl_frontend;
  localparam int    CLK_PERIOD = 10;
  localparam int    ADDR_W     = 5;
  localparam int    DEPTH      = 4;
  localparam logic [31:0] IDW  = 32'hC3A5_197E;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_en = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata;
  logic              irq;
  logic [7:0]        tx_char;
  logic              tx_pending;
  logic              tx_accept = 1'b0;
  logic [7:0]        rx_char = '0;
  logic              rx_push = 1'b0, rx_ferr = 1'b0;
  logic              baud_tick;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  int model_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_ctl_frontend #(.ADDR_W(ADDR_W), .FIFO_DEPTH(DEPTH), .ID_WORD(IDW)) i_serial_ctl_frontend (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_char(tx_char),
    .tx_pending(tx_pending), .tx_accept(tx_accept), .rx_char(rx_char),
    .rx_push(rx_push), .rx_ferr(rx_ferr), .baud_tick(baud_tick)
  );

  task automatic check(input string req, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // driver: pushes a received character and records what the FIFO should keep
  task automatic push_rx(input logic [7:0] c, input logic fe);
    @(negedge clk);
    rx_push = 1'b1; rx_char = c; rx_ferr = fe;
    @(negedge clk);
    rx_push = 1'b0; rx_ferr = 1'b0;
    if (model_cnt < DEPTH) begin
      exp_q.push_back(c);
      model_cnt++;
    end
  endtask

  // monitor side: each data read is compared with the oldest expected item
  task automatic pop_chk(input string req);
    logic [7:0] v;
    logic [7:0] e;
    rd(5'd16, v);
    e = 8'h00;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      model_cnt--;
    end
    check(req, v, e);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk);
    check(req, irq, exp);
  endtask

  task automatic accept_tx();
    @(negedge clk);
    tx_accept = 1'b1;
    @(negedge clk);
    tx_accept = 1'b0;
  endtask

  task automatic tick_period(input string req, input int exp);
    int n;
    n = 0;
    while (baud_tick !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (baud_tick !== 1'b1 && n < 2000);
    check(req, n, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    check("R10 irq", irq, 0);
    check("R10 tx_pending", tx_pending, 0);
    rd_chk("R10 status", 5'd20, 8'hA0);
    rd_chk("R10 divl", 5'd24, 8'h00);
    rd_chk("R10 divh", 5'd28, 8'h00);

    // R1 identification bytes
    rd_chk("R1 id0", 5'd0, 8'h7E);
    rd_chk("R1 id1", 5'd4, 8'h19);
    rd_chk("R1 id2", 5'd8, 8'hA5);
    rd_chk("R1 id3", 5'd12, 8'hC3);
    wr(5'd0, 8'hFF);
    rd_chk("R1 id0 after write", 5'd0, 8'h7E);

    // R2 unmapped offsets
    rd_chk("R2 offset1", 5'd1, 8'h00);
    rd_chk("R2 offset17", 5'd17, 8'h00);
    wr(5'd21, 8'h44);
    rd_chk("R2 status untouched", 5'd20, 8'hA0);

    // R3 transmit holding stage
    wr(5'd16, 8'h3C);
    check("R3 pending", tx_pending, 1);
    check("R3 char", tx_char, 8'h3C);
    rd_chk("R3 status busy", 5'd20, 8'h20);
    wr(5'd16, 8'h99);
    check("R3 ignored write", tx_char, 8'h3C);
    accept_tx();
    check("R3 drained", tx_pending, 0);
    rd_chk("R3 status empty", 5'd20, 8'hA0);

    // R5/R6 receive fill levels and overrun
    push_rx(8'h11, 1'b0);
    push_rx(8'h22, 1'b0);
    push_rx(8'h33, 1'b0);
    rd_chk("R5 one room left", 5'd20, 8'h90);
    push_rx(8'h44, 1'b0);
    rd_chk("R5 full", 5'd20, 8'h88);
    push_rx(8'h55, 1'b0);
    rd_chk("R6 overrun", 5'd20, 8'h8A);

    // R4 ordered reads
    for (int i = 0; i < DEPTH; i++) pop_chk("R4 order");
    pop_chk("R4 empty read");
    rd_chk("R4 R6 after drain", 5'd20, 8'hA2);

    // R7 sticky clear
    wr(5'd20, 8'h02);
    rd_chk("R7 keep oerr", 5'd20, 8'hA2);
    wr(5'd20, 8'h00);
    rd_chk("R7 clear oerr", 5'd20, 8'hA0);

    // R6 frame error
    push_rx(8'h66, 1'b1);
    rd_chk("R6 frame flag", 5'd20, 8'h81);
    pop_chk("R6 frame char stored");

    // R8 interrupt line
    wr(5'd20, 8'h05);
    irq_chk("R8 rx error irq", 1'b1);
    wr(5'd20, 8'h04);
    irq_chk("R8 rx idle", 1'b0);
    push_rx(8'h77, 1'b0);
    irq_chk("R8 rx data irq", 1'b1);
    pop_chk("R8 rx data");
    irq_chk("R8 rx drained", 1'b0);
    wr(5'd20, 8'h40);
    irq_chk("R8 tx empty irq", 1'b1);
    wr(5'd16, 8'h5A);
    irq_chk("R8 tx busy", 1'b0);
    accept_tx();
    irq_chk("R8 tx done", 1'b1);
    wr(5'd20, 8'h00);
    irq_chk("R8 disabled", 1'b0);

    // R7 read-only bits ignore writes
    wr(5'd20, 8'hB8);
    rd_chk("R7 ro bits", 5'd20, 8'hA0);

    // R9 baud divisor
    wr(5'd24, 8'h03);
    rd_chk("R9 divl", 5'd24, 8'h03);
    tick_period("R9 period 4", 4);
    @(negedge clk);
    check("R9 one cycle wide", baud_tick, 0);
    wr(5'd24, 8'h00);
    @(negedge clk);
    check("R9 div0 a", baud_tick, 1);
    @(negedge clk);
    check("R9 div0 b", baud_tick, 1);
    wr(5'd28, 8'h01);
    wr(5'd24, 8'h02);
    rd_chk("R9 divh", 5'd28, 8'h01);
    tick_period("R9 period 259", 259);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule